// File: doc/BRIEF.md
# Three-Phase Rotation Order Checker

This block watches three zero-crossing strobes, one for each voltage phase (A, B and C). Each strobe is high for one clock cycle and marks a rising crossing, from negative to positive. In correct operation the crossings follow the rotation A, B, C and then back to A. The block remembers which phase crossed last and compares every new crossing with the phase that should come next. When a crossing breaks the rotation, a sticky error status bit is set. This happens on every offending crossing, not only the first one.

Software controls the block through a small register interface: a mask input, a write strobe with one data bit, and an active-low interrupt. Writing a 1 clears the status bit. The checker only means something when three voltage sensors are wired. A two-bit wiring-configuration input therefore turns checking on only for the configured enable code, which defaults to 00. Under any other code the checker is idle and forgets the last phase it saw.

Top module: `phase_seq_check`

## Requirements
- R1: After synchronous reset, `err_status` is 0 and `irq_n` is 1.
- R2: When crossings follow A, B, C, A, ... in order, `err_status` is never set.
- R3: A crossing on C after a crossing on A, on A after B, or on B after C sets `err_status`. The bit is visible on the clock edge that samples the offending strobe.
- R4: A crossing on the same phase as the previous crossing sets `err_status`.
- R5: The first crossing after reset, or after the checker becomes enabled, only loads the last-phase memory and is never flagged.
- R6: When `wiring_cfg` differs from 00, no crossing sets `err_status` and the last-phase memory is cleared.
- R7: `irq_n` is 0 exactly when `err_status` is 1 and `irq_mask` is 1.
- R8: A write (`stat_wr`=1) with `stat_wdata`=1 clears `err_status`. A write with `stat_wdata`=0 leaves it unchanged.
- R9: If an error event and a clearing write occur in the same cycle, `err_status` stays set.
- R10: Crossing strobes on two or more phases in the same cycle count as an error, and they clear the last-phase memory.
- R11: Once set, `err_status` holds its value until a clearing write or a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| zx_a | input | 1 | Phase A rising-crossing strobe, one cycle wide |
| zx_b | input | 1 | Phase B rising-crossing strobe, one cycle wide |
| zx_c | input | 1 | Phase C rising-crossing strobe, one cycle wide |
| wiring_cfg | input | 2 | Wiring configuration; checking is active only at 00 |
| irq_mask | input | 1 | Interrupt enable for the error status bit |
| stat_wr | input | 1 | Write strobe for the status register |
| stat_wdata | input | 1 | Written value of the error bit; 1 clears the bit |
| err_status | output | 1 | Sticky rotation error status bit |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with its default parameters: a two-bit configuration field and an enable code of 00. With these values every configuration case is reachable, including the idle codes. The stimulus table goes through legal rotations, each kind of reversal, repeats, simultaneous strobes, and the transition from disabled back to enabled that re-arms the first-crossing rule. Directed steps then cover the interaction of the mask with an existing error and a reset that arrives while the error is set.

// File: rtl/phase_seq_pkg.sv
package phase_seq_pkg;

    typedef enum logic [1:0] {
        PH_NONE = 2'd0,
        PH_A    = 2'd1,
        PH_B    = 2'd2,
        PH_C    = 2'd3
    } phase_e;

    typedef struct packed {
        logic   hit;
        logic   multi;
        phase_e ph;
    } zx_evt_t;

    localparam int NUM_PHASES = 3;

    function automatic phase_e phase_after(input phase_e p);
        case (p)
            PH_A:    return PH_B;
            PH_B:    return PH_C;
            PH_C:    return PH_A;
            default: return PH_NONE;
        endcase
    endfunction

endpackage

// File: rtl/psd_zx_encode.sv
module psd_zx_encode
    import phase_seq_pkg::*;
(
    input  logic [NUM_PHASES-1:0] zx_vec,
    output zx_evt_t               evt
);
    always_comb begin
        evt       = '0;
        evt.hit   = |zx_vec;
        evt.multi = ($countones(zx_vec) > 1);
        if (zx_vec[0])      evt.ph = PH_A;
        else if (zx_vec[1]) evt.ph = PH_B;
        else if (zx_vec[2]) evt.ph = PH_C;
        else                evt.ph = PH_NONE;
    end
endmodule

// File: rtl/psd_order_track.sv
module psd_order_track
    import phase_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    enable,
    input  zx_evt_t evt,
    output logic    seq_err
);
    phase_e last_q;

    always_comb begin
        seq_err = 1'b0;
        if (enable && evt.hit) begin
            if (evt.multi)
                seq_err = 1'b1;
            else if (last_q != PH_NONE && evt.ph != phase_after(last_q))
                seq_err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !enable)
            last_q <= PH_NONE;
        else if (evt.hit)
            last_q <= evt.multi ? PH_NONE : evt.ph;
    end
endmodule

// File: rtl/psd_status_flag.sv
module psd_status_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic wr,
    input  logic wdata,
    input  logic mask,
    output logic status,
    output logic irq_n
);
    always_ff @(posedge clk) begin
        if (rst)
            status <= 1'b0;
        else if (set_evt)
            status <= 1'b1;
        else if (wr && wdata)
            status <= 1'b0;
    end

    assign irq_n = !(status && mask);
endmodule

// File: rtl/phase_seq_check.sv
module phase_seq_check
    import phase_seq_pkg::*;
#(
    parameter int                 CFG_W       = 2,
    parameter logic [CFG_W-1:0]   ENABLE_CODE = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             zx_a,
    input  logic             zx_b,
    input  logic             zx_c,
    input  logic [CFG_W-1:0] wiring_cfg,
    input  logic             irq_mask,
    input  logic             stat_wr,
    input  logic             stat_wdata,
    output logic             err_status,
    output logic             irq_n
);
    logic [NUM_PHASES-1:0] zx_vec;
    zx_evt_t               evt;
    logic                  chk_en;
    logic                  seq_err;

    assign zx_vec = {zx_c, zx_b, zx_a};
    assign chk_en = (wiring_cfg == ENABLE_CODE);

    psd_zx_encode u_enc (
        .zx_vec (zx_vec),
        .evt    (evt)
    );

    psd_order_track u_trk (
        .clk     (clk),
        .rst     (rst),
        .enable  (chk_en),
        .evt     (evt),
        .seq_err (seq_err)
    );

    psd_status_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_evt (seq_err),
        .wr      (stat_wr),
        .wdata   (stat_wdata),
        .mask    (irq_mask),
        .status  (err_status),
        .irq_n   (irq_n)
    );
endmodule

// File: rtl/phase_seq_check_sva.sv
module phase_seq_check_sva #(
    parameter int               CFG_W       = 2,
    parameter logic [CFG_W-1:0] ENABLE_CODE = '0
) (
    input logic             clk,
    input logic             rst,
    input logic             zx_a,
    input logic             zx_b,
    input logic             zx_c,
    input logic [CFG_W-1:0] wiring_cfg,
    input logic             irq_mask,
    input logic             stat_wr,
    input logic             stat_wdata,
    input logic             err_status,
    input logic             irq_n
);
    a_r1_reset_clears: assert property (@(posedge clk) rst |=> !err_status);

    a_r7_irq_needs_status: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> (err_status && irq_mask));

    a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_status && !(stat_wr && stat_wdata)) |=> err_status);

    a_r6_idle_no_set: assert property (@(posedge clk) disable iff (rst)
        (wiring_cfg != ENABLE_CODE && !err_status) |=> !err_status);

    a_r8_zero_write_keeps: assert property (@(posedge clk) disable iff (rst)
        (err_status && stat_wr && !stat_wdata) |=> err_status);

    a_r2_no_strobe_no_set: assert property (@(posedge clk) disable iff (rst)
        (!zx_a && !zx_b && !zx_c && !err_status) |=> !err_status);
endmodule

bind phase_seq_check phase_seq_check_sva #(
    .CFG_W       (CFG_W),
    .ENABLE_CODE (ENABLE_CODE)
) u_sva (
    .clk        (clk),
    .rst        (rst),
    .zx_a       (zx_a),
    .zx_b       (zx_b),
    .zx_c       (zx_c),
    .wiring_cfg (wiring_cfg),
    .irq_mask   (irq_mask),
    .stat_wr    (stat_wr),
    .stat_wdata (stat_wdata),
    .err_status (err_status),
    .irq_n      (irq_n)
);

// File: tb/phase_seq_check_bench.sv
module phase_seq_check_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       zx_a, zx_b, zx_c;
    logic [1:0] wiring_cfg;
    logic       irq_mask, stat_wr, stat_wdata;
    logic       err_status, irq_n;
    int         n_cmp = 0;
    int         n_bad = 0;

    always #10 clk = ~clk;

    phase_seq_check u_phase_seq_check (
        .clk(clk), .rst(rst), .zx_a(zx_a), .zx_b(zx_b), .zx_c(zx_c),
        .wiring_cfg(wiring_cfg), .irq_mask(irq_mask), .stat_wr(stat_wr),
        .stat_wdata(stat_wdata), .err_status(err_status), .irq_n(irq_n)
    );

    // Vector: {zx_c, zx_b, zx_a, cfg[1:0], wr, wdata, expected status}
    localparam int NV = 21;
    localparam logic [7:0] VEC [NV] = '{
        8'b000_00_00_0, // idle                         R1
        8'b001_00_00_0, // A first                      R5
        8'b010_00_00_0, // B                            R2
        8'b100_00_00_0, // C                            R2
        8'b001_00_00_0, // A                            R2
        8'b100_00_00_1, // C after A                    R3
        8'b000_00_11_0, // clear                        R8
        8'b010_00_00_1, // B after C                    R3
        8'b001_00_11_1, // A after B plus clear         R3 R9
        8'b000_00_11_0, // clear                        R8
        8'b001_00_00_1, // A repeated                   R4
        8'b000_00_10_1, // write 0 keeps                R8
        8'b000_00_11_0, // clear                        R8
        8'b100_01_00_0, // C under idle config          R6
        8'b010_01_00_0, // B under idle config          R6
        8'b100_00_00_0, // C first after enable         R5
        8'b001_00_00_0, // A legal after C              R2
        8'b011_00_00_1, // A and B together             R10
        8'b000_00_11_0, // clear                        R8
        8'b010_00_00_0, // B first after multi          R10
        8'b100_00_00_0  // C legal                      R2
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] zx, input logic [1:0] cfg,
                        input logic wr, input logic wd);
        @(negedge clk);
        {zx_c, zx_b, zx_a} = zx;
        wiring_cfg = cfg;
        stat_wr = wr;
        stat_wdata = wd;
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; {zx_c, zx_b, zx_a} = 3'b000; wiring_cfg = 2'b00;
        irq_mask = 1'b1; stat_wr = 1'b0; stat_wdata = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        check("R1 status", err_status, 1'b0);
        check("R1 irq_n", irq_n, 1'b1);
        @(negedge clk) rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][7:5], VEC[i][4:3], VEC[i][2], VEC[i][1]);
            check($sformatf("vec%0d status R2-set", i), err_status, VEC[i][0]);
            check($sformatf("vec%0d R7 irq_n", i), irq_n, !VEC[i][0]);
        end

        // R7: masked error keeps irq high, unmasking drops it
        @(negedge clk) irq_mask = 1'b0;
        step(3'b010, 2'b00, 1'b0, 1'b0); // B after C: R3 reversal
        check("R3 status masked", err_status, 1'b1);
        check("R7 irq_n masked", irq_n, 1'b1);
        @(negedge clk) irq_mask = 1'b1;
        #1;
        check("R7 irq_n unmasked", irq_n, 1'b0);
        // R11: holds across idle cycles
        repeat (3) step(3'b000, 2'b00, 1'b0, 1'b0);
        check("R11 sticky", err_status, 1'b1);
        // R1: reset while set
        @(negedge clk) rst = 1'b1;
        @(posedge clk); #2;
        check("R1 reset clears", err_status, 1'b0);
        check("R1 reset irq_n", irq_n, 1'b1);
        @(negedge clk) rst = 1'b0;
        // R5: first crossing after reset, even C, not flagged
        step(3'b100, 2'b00, 1'b0, 1'b0);
        check("R5 first after reset", err_status, 1'b0);
        step(3'b100, 2'b00, 1'b0, 1'b0);
        check("R4 repeat C", err_status, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule